// File: doc/BRIEF.md
# Masked Vector Byte Permute Unit

This block rearranges the bytes of a 512-bit vector in one clock. Each destination lane takes one byte of a data vector. An index vector picks that byte, and it carries one index byte per lane. The caller also selects the active vector length: 16, 32 or 64 lanes. That choice sets how many low bits of each index byte count and how many destination lanes are live. Lanes at or above the active length always come out as zero.

A per-lane write mask can gate the result. When masking is on and a lane's mask bit is clear, the lane takes one of two values, set by a mode bit. In zeroing mode it becomes 0x00. In merging mode it keeps the byte that the caller supplies as the previous destination value. One data byte may feed any number of lanes in the same operation.

The result is captured in an output register. A two-state controller (`ST_EMPTY`, `ST_LOADED`) tracks whether that register holds a fresh result.
- `in_valid` high moves the controller to `ST_LOADED` from either state.
- `in_valid` low moves it to `ST_EMPTY` from either state.
- `out_valid` is high exactly while the controller is in `ST_LOADED`.

Top module: `vbyte_perm_unit`

## Requirements
- R1: At the full 64-lane length, each live destination lane j receives the data byte whose position is given by index byte j. Byte j occupies bits [8j+7:8j] of every vector.
- R2: Only the low 4, 5 or 6 bits of each index byte select the source byte, for the 16-, 32- and 64-lane lengths respectively. The remaining index bits have no effect.
- R3: A single data byte may appear in several destination lanes of one result.
- R4: A live lane receives its permuted byte when `mask_en` is 0, or when its `lane_mask` bit (bit j for lane j) is 1.
- R5: A live lane whose mask bit is 0 is written with 0x00 when `mask_en` is 1 and `zero_mode` is 1.
- R6: A live lane whose mask bit is 0 receives the byte of `prev_vec` at the same position when `mask_en` is 1 and `zero_mode` is 0.
- R7: `len_sel` 2'b00 gives 16 live lanes, 2'b01 gives 32 and 2'b10 gives 64. Every lane at or above the live count is 0x00 whatever the mask, mode and previous value. Mask bits of those lanes are ignored.
- R8: `len_sel` 2'b11 behaves exactly like 2'b10.
- R9: A transfer is taken on a rising edge with `in_valid` high. Its result appears on `out_vec` with `out_valid` high after that same edge. After an edge with `in_valid` low, `out_valid` is low and `out_vec` holds its previous value.
- R10: A synchronous active-high `rst` clears `out_vec` to zero and drops `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| len_sel | input | 2 | Active length: 00=16 lanes, 01=32, 10/11=64 |
| mask_en | input | 1 | Apply the per-lane write mask |
| zero_mode | input | 1 | 1: masked lanes are zeroed, 0: masked lanes are merged |
| idx_vec | input | 512 | One index byte per destination lane |
| src_vec | input | 512 | Data vector whose bytes are picked |
| prev_vec | input | 512 | Previous destination value, used for merging |
| lane_mask | input | 64 | Per-lane write enable, bit j for lane j |
| out_valid | output | 1 | `out_vec` holds a result taken on the last edge |
| out_vec | output | 512 | Registered result |

## Verification
The checker watches several properties on every cycle:
- the timing of `out_valid` against `in_valid`;
- that `out_vec` holds steady while no transfer is taken;
- the effect of reset;
- that the upper lanes are zero at the 16-lane length;
- all-zero and all-merge results when the whole mask is clear;
- a broadcast from index zero.

Some behaviours only the directed scenarios can show:
- that the correct byte lands in each lane for mixed index patterns;
- that high index bits are dropped at each length;
- lane-by-lane mixing of mask bits;
- the 2'b11 length alias.

// File: rtl/vbp_pkg.sv
`timescale 1ns/1ps
package vbp_pkg;

    // Length-select encoding; 2'b11 is decoded as the full length.
    typedef enum logic [1:0] {
        LEN_QUARTER = 2'b00,
        LEN_HALF    = 2'b01,
        LEN_FULL    = 2'b10,
        LEN_ALIAS   = 2'b11
    } vlen_e;

    // Result-register occupancy.
    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } occ_e;

endpackage

// File: rtl/vbp_len_decode.sv
`timescale 1ns/1ps
module vbp_len_decode
    import vbp_pkg::*;
#(
    parameter int VEC_BYTES = 64,
    localparam int IDX_W    = $clog2(VEC_BYTES),
    localparam int CNT_W    = IDX_W + 1
) (
    input  logic [1:0]           len_sel,
    output logic [IDX_W-1:0]     idx_keep,
    output logic [VEC_BYTES-1:0] lane_live
);
    localparam int Q_LANES = VEC_BYTES / 4;
    localparam int H_LANES = VEC_BYTES / 2;

    logic [CNT_W-1:0] lane_cnt;

    always_comb begin
        unique case (vlen_e'(len_sel))
            LEN_QUARTER: lane_cnt = CNT_W'(Q_LANES);
            LEN_HALF:    lane_cnt = CNT_W'(H_LANES);
            LEN_FULL,
            LEN_ALIAS:   lane_cnt = CNT_W'(VEC_BYTES);
            default:     lane_cnt = CNT_W'(VEC_BYTES);
        endcase
        idx_keep = IDX_W'(lane_cnt - CNT_W'(1));
    end

    for (genvar j = 0; j < VEC_BYTES; j++) begin : g_live
        assign lane_live[j] = (CNT_W'(j) < lane_cnt);
    end

endmodule

// File: rtl/vbp_byte_xbar.sv
`timescale 1ns/1ps
module vbp_byte_xbar #(
    parameter int VEC_BYTES = 64,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(VEC_BYTES),
    localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
    input  logic [VEC_W-1:0] idx_vec,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [IDX_W-1:0] idx_keep,
    output logic [VEC_W-1:0] perm_vec
);
    logic [BYTE_W-1:0] src_bytes [VEC_BYTES];

    for (genvar s = 0; s < VEC_BYTES; s++) begin : g_split
        assign src_bytes[s] = src_vec[s*BYTE_W +: BYTE_W];
    end

    // One read port per destination lane; the same source may be read by many.
    for (genvar j = 0; j < VEC_BYTES; j++) begin : g_lane
        logic [IDX_W-1:0] sel;
        assign sel = idx_vec[j*BYTE_W +: IDX_W] & idx_keep;
        assign perm_vec[j*BYTE_W +: BYTE_W] = src_bytes[sel];
    end

endmodule

// File: rtl/vbp_lane_write.sv
`timescale 1ns/1ps
module vbp_lane_write #(
    parameter int VEC_BYTES = 64,
    parameter int BYTE_W    = 8,
    localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
    input  logic [VEC_W-1:0]     perm_vec,
    input  logic [VEC_W-1:0]     prev_vec,
    input  logic [VEC_BYTES-1:0] lane_mask,
    input  logic [VEC_BYTES-1:0] lane_live,
    input  logic                 mask_en,
    input  logic                 zero_mode,
    output logic [VEC_W-1:0]     lane_out
);
    for (genvar j = 0; j < VEC_BYTES; j++) begin : g_lane
        always_comb begin
            if (!lane_live[j]) begin
                lane_out[j*BYTE_W +: BYTE_W] = '0;
            end else if (!mask_en || lane_mask[j]) begin
                lane_out[j*BYTE_W +: BYTE_W] = perm_vec[j*BYTE_W +: BYTE_W];
            end else if (zero_mode) begin
                lane_out[j*BYTE_W +: BYTE_W] = '0;
            end else begin
                lane_out[j*BYTE_W +: BYTE_W] = prev_vec[j*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/vbyte_perm_unit.sv
`timescale 1ns/1ps
module vbyte_perm_unit
    import vbp_pkg::*;
#(
    parameter int VEC_BYTES = 64,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(VEC_BYTES),
    localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           len_sel,
    input  logic                 mask_en,
    input  logic                 zero_mode,
    input  logic [VEC_W-1:0]     idx_vec,
    input  logic [VEC_W-1:0]     src_vec,
    input  logic [VEC_W-1:0]     prev_vec,
    input  logic [VEC_BYTES-1:0] lane_mask,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     out_vec
);
    logic [IDX_W-1:0]     idx_keep;
    logic [VEC_BYTES-1:0] lane_live;
    logic [VEC_W-1:0]     perm_vec;
    logic [VEC_W-1:0]     lane_out;
    occ_e                 state_q, state_d;

    vbp_len_decode #(.VEC_BYTES(VEC_BYTES)) u_len (
        .len_sel   (len_sel),
        .idx_keep  (idx_keep),
        .lane_live (lane_live)
    );

    vbp_byte_xbar #(.VEC_BYTES(VEC_BYTES), .BYTE_W(BYTE_W)) u_xbar (
        .idx_vec  (idx_vec),
        .src_vec  (src_vec),
        .idx_keep (idx_keep),
        .perm_vec (perm_vec)
    );

    vbp_lane_write #(.VEC_BYTES(VEC_BYTES), .BYTE_W(BYTE_W)) u_write (
        .perm_vec  (perm_vec),
        .prev_vec  (prev_vec),
        .lane_mask (lane_mask),
        .lane_live (lane_live),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .lane_out  (lane_out)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Output register: loads only on a taken transfer.
    always_ff @(posedge clk) begin
        if (rst)           out_vec <= '0;
        else if (in_valid) out_vec <= lane_out;
    end

    assign out_valid = (state_q == ST_LOADED);

endmodule

// File: rtl/vbp_checker.sv
`timescale 1ns/1ps
module vbp_checker #(
    parameter int VEC_BYTES = 64,
    parameter int BYTE_W    = 8,
    localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [1:0]           len_sel,
    input logic                 mask_en,
    input logic                 zero_mode,
    input logic [VEC_W-1:0]     idx_vec,
    input logic [VEC_W-1:0]     src_vec,
    input logic [VEC_W-1:0]     prev_vec,
    input logic [VEC_BYTES-1:0] lane_mask,
    input logic                 out_valid,
    input logic [VEC_W-1:0]     out_vec
);
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec));

    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_vec == '0));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && len_sel == 2'b00) |=> (out_vec[VEC_W-1:VEC_W/4] == '0));

    a_r5_all_zeroed: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && zero_mode && lane_mask == '0) |=> (out_vec == '0));

    a_r6_all_merged: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !zero_mode && lane_mask == '0 && len_sel == 2'b10)
        |=> (out_vec == $past(prev_vec)));

    a_r3_broadcast: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mask_en && len_sel == 2'b10 && idx_vec == '0)
        |=> (out_vec == {VEC_BYTES{$past(src_vec[BYTE_W-1:0])}}));

endmodule

bind vbyte_perm_unit vbp_checker #(.VEC_BYTES(VEC_BYTES), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .len_sel   (len_sel),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .idx_vec   (idx_vec),
    .src_vec   (src_vec),
    .prev_vec  (prev_vec),
    .lane_mask (lane_mask),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/vbyte_perm_unit_tb_top.sv
`timescale 1ns/1ps
module vbyte_perm_unit_tb_top;
    localparam int NB = 64;
    localparam int VW = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    len_sel = 2'b10;
    logic          mask_en = 1'b0;
    logic          zero_mode = 1'b0;
    logic [VW-1:0] idx_vec = '0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] prev_vec = '0;
    logic [NB-1:0] lane_mask = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    vbyte_perm_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .len_sel(len_sel),
        .mask_en(mask_en), .zero_mode(zero_mode), .idx_vec(idx_vec),
        .src_vec(src_vec), .prev_vec(prev_vec), .lane_mask(lane_mask),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    // Expected result built from the requirement text.
    function automatic logic [VW-1:0] expect_vec(
        input logic [VW-1:0] iv, input logic [VW-1:0] sv, input logic [VW-1:0] pv,
        input logic [NB-1:0] mk, input logic [1:0] ls, input logic me, input logic zm);
        logic [VW-1:0] r;
        int live;
        int pick;
        live = (ls == 2'b00) ? 16 : (ls == 2'b01) ? 32 : 64;
        r = '0;
        for (int j = 0; j < NB; j++) begin
            pick = int'(iv[j*8 +: 8]) % live;
            if (j >= live)              r[j*8 +: 8] = 8'h00;
            else if (!me || mk[j])      r[j*8 +: 8] = sv[pick*8 +: 8];
            else if (zm)                r[j*8 +: 8] = 8'h00;
            else                        r[j*8 +: 8] = pv[j*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one transfer at a falling edge; results are sampled one falling edge later.
    task automatic issue(input logic [VW-1:0] iv, input logic [VW-1:0] sv, input logic [VW-1:0] pv,
                         input logic [NB-1:0] mk, input logic [1:0] ls, input logic me, input logic zm);
        idx_vec = iv; src_vec = sv; prev_vec = pv; lane_mask = mk;
        len_sel = ls; mask_en = me; zero_mode = zm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R10 out_valid in reset", out_valid, 1'b0);
        check_vec("R10 out_vec in reset", out_vec, '0);
        rst = 1'b0;
    endtask

    task automatic t_identity_reverse();
        logic [VW-1:0] iv, sv, ex;
        sv = rnd_vec();
        for (int j = 0; j < NB; j++) iv[j*8 +: 8] = 8'(j);
        issue(iv, sv, '0, '0, 2'b10, 1'b0, 1'b0);
        check_vec("R1 identity", out_vec, sv);
        for (int j = 0; j < NB; j++) begin
            iv[j*8 +: 8] = 8'(NB - 1 - j);
            ex[j*8 +: 8] = sv[(NB-1-j)*8 +: 8];
        end
        issue(iv, sv, '0, '0, 2'b10, 1'b0, 1'b0);
        check_vec("R1 reverse", out_vec, ex);
    endtask

    task automatic t_broadcast();
        logic [VW-1:0] iv, sv;
        sv = rnd_vec();
        for (int j = 0; j < NB; j++) iv[j*8 +: 8] = 8'd5;
        issue(iv, sv, '0, '0, 2'b10, 1'b0, 1'b0);
        check_vec("R3 broadcast", out_vec, {NB{sv[5*8 +: 8]}});
    endtask

    task automatic t_truncate();
        logic [VW-1:0] iv, sv;
        for (int ls = 0; ls < 3; ls++) begin
            iv = rnd_vec(); sv = rnd_vec();
            issue(iv, sv, '0, '0, 2'(ls), 1'b0, 1'b0);
            check_vec("R2 index truncation", out_vec, expect_vec(iv, sv, '0, '0, 2'(ls), 1'b0, 1'b0));
        end
        sv = rnd_vec(); iv = '0; iv[7:0] = 8'hF3;
        issue(iv, sv, '0, '0, 2'b00, 1'b0, 1'b0);
        check_vec("R2 lane0 at 16 lanes", {{(VW-8){1'b0}}, out_vec[7:0]}, {{(VW-8){1'b0}}, sv[3*8 +: 8]});
    endtask

    task automatic t_mask_modes();
        logic [VW-1:0] iv, sv, pv;
        logic [NB-1:0] mk;
        iv = rnd_vec(); sv = rnd_vec(); pv = rnd_vec();
        mk = {$urandom, $urandom};
        issue(iv, sv, pv, mk, 2'b10, 1'b1, 1'b0);
        check_vec("R6 merge masked lanes", out_vec, expect_vec(iv, sv, pv, mk, 2'b10, 1'b1, 1'b0));
        issue(iv, sv, pv, mk, 2'b10, 1'b1, 1'b1);
        check_vec("R5 zero masked lanes", out_vec, expect_vec(iv, sv, pv, mk, 2'b10, 1'b1, 1'b1));
        issue(iv, sv, pv, '1, 2'b10, 1'b1, 1'b1);
        check_vec("R4 all mask bits set", out_vec, expect_vec(iv, sv, pv, '0, 2'b10, 1'b0, 1'b0));
        issue(iv, sv, pv, '0, 2'b10, 1'b0, 1'b1);
        check_vec("R4 masking disabled", out_vec, expect_vec(iv, sv, pv, '0, 2'b10, 1'b0, 1'b0));
    endtask

    task automatic t_upper_zero();
        logic [VW-1:0] iv, sv, pv;
        iv = rnd_vec(); sv = rnd_vec(); pv = '1;
        issue(iv, sv, pv, {32'h0, 32'hFFFF_FFFF}, 2'b01, 1'b1, 1'b0);
        check_vec("R7 upper lanes zero at 32", out_vec[VW-1:VW/2], '0);
        check_vec("R7 live lanes at 32", out_vec, expect_vec(iv, sv, pv, '1, 2'b01, 1'b0, 1'b0));
        issue(iv, sv, pv, {48'h0, 16'h00FF}, 2'b00, 1'b1, 1'b0);
        check_vec("R7 16 lanes merge, upper zero", out_vec,
                  expect_vec(iv, sv, pv, {48'h0, 16'h00FF}, 2'b00, 1'b1, 1'b0));
    endtask

    task automatic t_alias();
        logic [VW-1:0] iv, sv, pv;
        logic [NB-1:0] mk;
        iv = rnd_vec(); sv = rnd_vec(); pv = rnd_vec(); mk = {$urandom, $urandom};
        issue(iv, sv, pv, mk, 2'b11, 1'b1, 1'b0);
        check_vec("R8 len 11 as full", out_vec, expect_vec(iv, sv, pv, mk, 2'b10, 1'b1, 1'b0));
    endtask

    task automatic t_handshake();
        logic [VW-1:0] iv, sv, held;
        iv = rnd_vec(); sv = rnd_vec();
        issue(iv, sv, '0, '0, 2'b10, 1'b0, 1'b0);
        check_bit("R9 out_valid after transfer", out_valid, 1'b1);
        held = out_vec;
        src_vec = rnd_vec(); idx_vec = rnd_vec();
        @(negedge clk);
        check_bit("R9 out_valid after idle", out_valid, 1'b0);
        check_vec("R9 data held while idle", out_vec, held);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_identity_reverse();
        t_broadcast();
        t_truncate();
        t_mask_modes();
        t_upper_zero();
        t_alias();
        t_handshake();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule